// File: doc/BRIEF.md
# Display sync and blanking generator

This block produces the raster timing for a character- or pixel-based display controller. Two programmable phase counters run on the character clock. The horizontal counter steps every clock. The vertical counter steps once per completed line. From them the block derives horizontal sync, vertical sync and a blanking output. Blanking also covers the time between a sync-set command and the following display-start command. This keeps the screen dark while the timing is being reconfigured.

Several controllers can run locked together. One unit, in master mode, drives its vertical sync onto a shared line. The others, in slave mode, treat that line as an input, and each rising edge on it sends their counters back to the frame origin. When attached to dynamic RAM, the block uses each horizontal sync interval as a refresh slot. During that interval it flags that drawing must pause and that a refresh row address is valid. The row address advances once per sync pulse and wraps at a programmable row count.

The horizontal line is made of four phases, visited in this fixed order: ACTIVE, FRONT (front porch), SYNC, BACK (back porch), then ACTIVE again. Each phase lasts its programmed number of clocks. The vertical frame uses the same four phases, counted in lines. The phase machine has two kinds of transition. It takes "phase done" when the last count of the current phase is reached on a step. It takes "restart" from any phase to ACTIVE with count 0. The display gate is a two-state machine, HIDDEN and SHOWN. It takes "show" from HIDDEN to SHOWN on a display-start without a sync-set. It takes "hide" from SHOWN to HIDDEN on a sync-set. The frame origin is the horizontal ACTIVE count 0 of vertical ACTIVE line 0.

Top module: `sync_display_gen`

## Requirements
- R1: Each line consists of h_active clocks of ACTIVE, then h_front clocks of FRONT, then h_sync clocks of SYNC, then h_back clocks of BACK. hsync_o is 1 exactly during SYNC. All lengths are at least 1.
- R2: Each frame consists of v_active lines of ACTIVE, then v_front lines of FRONT, then v_sync lines of SYNC, then v_back lines of BACK. vsync_o is 1 exactly during vertical SYNC. The vertical phase changes only at the clock edge that ends a line.
- R3: blank_o is 1 whenever the horizontal phase is not ACTIVE.
- R4: blank_o is 1 whenever the vertical phase is not ACTIVE.
- R5: A sync_set sampled at a clock edge sends both counters to the frame origin at that edge and enters HIDDEN. blank_o then stays 1 until a disp_start is sampled, after which SHOWN applies from that edge. When both strobes arrive together, sync_set wins.
- R6: With master_mode = 1, vsync_oe is 1 and vsync_i has no effect on the timing.
- R7: With master_mode = 0, vsync_oe is 0. A 0-to-1 change of vsync_i sends both counters to the frame origin at the first clock edge where vsync_i is seen high. Holding vsync_i high afterwards does not restart them again. vsync_o keeps showing the internal vertical sync.
- R8: refresh_valid and draw_hold are both equal to hsync_o AND dram_mode.
- R9: With dram_mode = 1, refresh_addr steps by one at the edge where hsync_o falls. After refresh_rows - 1 it goes back to 0. It holds steady while hsync_o is 1, and it never changes while dram_mode = 0.
- R10: During and right after reset, the block is at the frame origin and HIDDEN, with refresh_addr = 0. So hsync_o = 0, vsync_o = 0, blank_o = 1 and refresh_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: drive vertical sync; 0: follow vsync_i |
| dram_mode | input | 1 | Enables refresh slots during horizontal sync |
| sync_set | input | 1 | Sync-set command strobe |
| disp_start | input | 1 | Display-start command strobe |
| h_active | input | HW | Visible clocks per line |
| h_front | input | HW | Horizontal front porch, clocks |
| h_sync | input | HW | Horizontal sync width, clocks |
| h_back | input | HW | Horizontal back porch, clocks |
| v_active | input | VW | Visible lines per frame |
| v_front | input | VW | Vertical front porch, lines |
| v_sync | input | VW | Vertical sync width, lines |
| v_back | input | VW | Vertical back porch, lines |
| refresh_rows | input | RW+1 | Number of refresh rows before wrap |
| vsync_i | input | 1 | Shared vertical sync line seen as input |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Internal vertical sync |
| vsync_oe | output | 1 | Output enable for the shared vertical sync line |
| blank_o | output | 1 | Blanking |
| refresh_valid | output | 1 | Refresh row address is valid |
| draw_hold | output | 1 | Drawing must pause |
| refresh_addr | output | RW | Refresh row address |

## Verification
The bench measures where the sync pulses and blanking start and stop in whole clocks from a known origin. An off-by-one phase length would move every one of those edges. The bench holds vsync_i high throughout a master-mode run: a design that listens to it in master mode would be pulled back to the origin. In slave mode the bench holds the restart pulse for several clocks; a design that restarts on the level rather than the edge would hold hsync off. The bench also issues sync-set and display-start together, checks that blanking persists while display has not yet been started, and checks that the refresh address wraps at the row count and holds while dynamic RAM mode is off.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;

    typedef enum logic {
        SCR_HIDDEN = 1'b0,
        SCR_SHOWN  = 1'b1
    } screen_e;
endpackage

// File: rtl/tim_axis.sv
module tim_axis
    import sdg_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_fp,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    output phase_e       phase,
    output logic         period_end,
    output logic         sync_exit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt, cnt_nxt, cur_len;
    phase_e       phase_nxt, phase_after;
    logic         last;

    // phase length and successor
    always_comb begin
        unique case (phase)
            PH_ACTIVE: begin cur_len = len_act;  phase_after = PH_FRONT;  end
            PH_FRONT:  begin cur_len = len_fp;   phase_after = PH_SYNC;   end
            PH_SYNC:   begin cur_len = len_sync; phase_after = PH_BACK;   end
            PH_BACK:   begin cur_len = len_back; phase_after = PH_ACTIVE; end
            default:   begin cur_len = len_act;  phase_after = PH_ACTIVE; end
        endcase
        last = (cnt >= cur_len - ONE);
    end

    // next state: restart beats phase done
    always_comb begin
        phase_nxt = phase;
        cnt_nxt   = cnt;
        if (restart) begin
            phase_nxt = PH_ACTIVE;
            cnt_nxt   = '0;
        end else if (step) begin
            if (last) begin
                phase_nxt = phase_after;
                cnt_nxt   = '0;
            end else begin
                cnt_nxt = cnt + ONE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ACTIVE;
            cnt   <= '0;
        end else begin
            phase <= phase_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // derived strobes
    always_comb begin
        period_end = !restart && step && last && (phase == PH_BACK);
        sync_exit  = (phase == PH_SYNC) && (phase_nxt != PH_SYNC);
    end

    assert_front_goes_to_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FRONT && !restart) |=> (phase == PH_FRONT || phase == PH_SYNC));

    assert_holds_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> ($stable(phase) && $stable(cnt)));

    assert_restart_reaches_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == PH_ACTIVE && cnt == '0));
endmodule

// File: rtl/scr_gate.sv
module scr_gate
    import sdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_set,
    input  logic disp_start,
    output logic shown
);
    screen_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SCR_HIDDEN: if (disp_start && !sync_set) state_nxt = SCR_SHOWN;
            SCR_SHOWN:  if (sync_set)                state_nxt = SCR_HIDDEN;
            default:                                 state_nxt = SCR_HIDDEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SCR_HIDDEN;
        else        state <= state_nxt;
    end

    always_comb shown = (state == SCR_SHOWN);

    assert_set_hides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_set |=> !shown);

    assert_start_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_start && !sync_set) |=> shown);
endmodule

// File: rtl/rfsh_ctr.sv
module rfsh_ctr #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dram_mode,
    input  logic          sync_exit,
    input  logic [RW:0]   rows,
    output logic [RW-1:0] addr
);
    localparam logic [RW:0] ONE_W = (RW+1)'(1);

    logic [RW:0] rows_m1;
    logic        wrap;

    always_comb begin
        rows_m1 = rows - ONE_W;
        wrap    = ({1'b0, addr} >= rows_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (dram_mode && sync_exit) begin
            addr <= wrap ? '0 : addr + RW'(1);
        end
    end

    assert_frozen_outside_dram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_mode |=> $stable(addr));
endmodule

// File: rtl/sync_display_gen.sv
module sync_display_gen
    import sdg_pkg::*;
#(
    parameter int HW = 10,
    parameter int VW = 10,
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          dram_mode,
    input  logic          sync_set,
    input  logic          disp_start,
    input  logic [HW-1:0] h_active,
    input  logic [HW-1:0] h_front,
    input  logic [HW-1:0] h_sync,
    input  logic [HW-1:0] h_back,
    input  logic [VW-1:0] v_active,
    input  logic [VW-1:0] v_front,
    input  logic [VW-1:0] v_sync,
    input  logic [VW-1:0] v_back,
    input  logic [RW:0]   refresh_rows,
    input  logic          vsync_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          vsync_oe,
    output logic          blank_o,
    output logic          refresh_valid,
    output logic          draw_hold,
    output logic [RW-1:0] refresh_addr
);
    phase_e h_phase, v_phase;
    logic   line_end, frame_end, h_sync_exit, v_sync_exit_unused;
    logic   vs_q, slave_edge, restart, shown;

    // edge detector on the shared vertical line
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync_i;
    end

    always_comb begin
        slave_edge = !master_mode && vsync_i && !vs_q;
        restart    = sync_set || slave_edge;
    end

    tim_axis #(.W(HW)) i_h_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step       (1'b1),
        .len_act    (h_active),
        .len_fp     (h_front),
        .len_sync   (h_sync),
        .len_back   (h_back),
        .phase      (h_phase),
        .period_end (line_end),
        .sync_exit  (h_sync_exit)
    );

    tim_axis #(.W(VW)) i_v_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step       (line_end),
        .len_act    (v_active),
        .len_fp     (v_front),
        .len_sync   (v_sync),
        .len_back   (v_back),
        .phase      (v_phase),
        .period_end (frame_end),
        .sync_exit  (v_sync_exit_unused)
    );

    scr_gate i_scr_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_set   (sync_set),
        .disp_start (disp_start),
        .shown      (shown)
    );

    rfsh_ctr #(.RW(RW)) i_rfsh_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .dram_mode (dram_mode),
        .sync_exit (h_sync_exit),
        .rows      (refresh_rows),
        .addr      (refresh_addr)
    );

    // output process
    always_comb begin
        hsync_o       = (h_phase == PH_SYNC);
        vsync_o       = (v_phase == PH_SYNC);
        vsync_oe      = master_mode;
        blank_o       = !shown || (h_phase != PH_ACTIVE) || (v_phase != PH_ACTIVE);
        refresh_valid = dram_mode && hsync_o;
        draw_hold     = dram_mode && hsync_o;
    end

    assert_hblank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_phase != PH_ACTIVE) |-> blank_o);

    assert_vblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_phase != PH_ACTIVE) |-> blank_o);

    assert_frame_wraps_to_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !restart) |=> (v_phase == PH_ACTIVE));

    assert_refresh_only_in_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_valid |-> (hsync_o && draw_hold));

    assert_addr_steady_in_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |=> (!hsync_o || $stable(refresh_addr)));

    assert_v_sync_exit_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_sync_exit_unused && !restart) |=> (v_phase == PH_BACK));
endmodule

// File: tb/test_sync_display_gen.sv
module test_sync_display_gen;
    localparam int HW = 10;
    localparam int VW = 10;
    localparam int RW = 9;
    localparam int NV = 14;

    typedef struct packed {
        logic [7:0] k;
        logic       hs;
        logic       vs;
        logic       bl;
    } vec_t;

    // positions after origin; line = 13 clocks (6 act, 2 fp, 3 sync, 2 bp), frame = 8 lines
    localparam vec_t TBL [NV] = '{
        '{8'd1,   1'b0, 1'b0, 1'b0},
        '{8'd5,   1'b0, 1'b0, 1'b0},
        '{8'd6,   1'b0, 1'b0, 1'b1},
        '{8'd8,   1'b1, 1'b0, 1'b1},
        '{8'd10,  1'b1, 1'b0, 1'b1},
        '{8'd11,  1'b0, 1'b0, 1'b1},
        '{8'd13,  1'b0, 1'b0, 1'b0},
        '{8'd52,  1'b0, 1'b0, 1'b1},
        '{8'd64,  1'b0, 1'b0, 1'b1},
        '{8'd65,  1'b0, 1'b1, 1'b1},
        '{8'd73,  1'b1, 1'b1, 1'b1},
        '{8'd91,  1'b0, 1'b0, 1'b1},
        '{8'd104, 1'b0, 1'b0, 1'b0},
        '{8'd112, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, master_mode, dram_mode, sync_set, disp_start, vsync_i;
    logic [HW-1:0] h_active, h_front, h_sync, h_back;
    logic [VW-1:0] v_active, v_front, v_sync, v_back;
    logic [RW:0]   refresh_rows;
    logic hsync_o, vsync_o, vsync_oe, blank_o, refresh_valid, draw_hold;
    logic [RW-1:0] refresh_addr;

    int checks = 0;
    int failures = 0;
    int cur = 0;
    int exp_ref = 0;
    logic prev_hs = 1'b0;
    logic done = 1'b0;
    logic [RW-1:0] a0;

    always #10 clk = ~clk;

    sync_display_gen #(.HW(HW), .VW(VW), .RW(RW)) i_sync_display_gen (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .dram_mode(dram_mode),
        .sync_set(sync_set), .disp_start(disp_start),
        .h_active(h_active), .h_front(h_front), .h_sync(h_sync), .h_back(h_back),
        .v_active(v_active), .v_front(v_front), .v_sync(v_sync), .v_back(v_back),
        .refresh_rows(refresh_rows), .vsync_i(vsync_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .vsync_oe(vsync_oe), .blank_o(blank_o),
        .refresh_valid(refresh_valid), .draw_hold(draw_hold), .refresh_addr(refresh_addr)
    );

    // reference for the refresh address: counts falling hsync edges seen in dram mode
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            exp_ref = 0;
            prev_hs = 1'b0;
        end else begin
            if (prev_hs && !hsync_o && dram_mode)
                exp_ref = (exp_ref + 1 == 5) ? 0 : exp_ref + 1;
            prev_hs = hsync_o;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic go_to(input int k);
        repeat (k - cur) @(posedge clk);
        #5;
        cur = k;
    endtask

    task automatic origin_now();
        @(posedge clk);
        #5;
        cur = 0;
    endtask

    initial begin
        rst_n = 1'b0; master_mode = 1'b1; dram_mode = 1'b1;
        sync_set = 1'b0; disp_start = 1'b0; vsync_i = 1'b0;
        h_active = 10'd6; h_front = 10'd2; h_sync = 10'd3; h_back = 10'd2;
        v_active = 10'd4; v_front = 10'd1; v_sync = 10'd2; v_back = 10'd1;
        refresh_rows = 10'd5;
        repeat (3) @(posedge clk);
        #5;
        // R10: reset state
        chk("R10", "hsync", int'(hsync_o), 0);
        chk("R10", "vsync", int'(vsync_o), 0);
        chk("R10", "blank", int'(blank_o), 1);
        chk("R10", "refresh_addr", int'(refresh_addr), 0);
        chk("R10", "refresh_valid", int'(refresh_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        cur = 0;
        go_to(2);
        // R5: no display-start yet, so blanked in the visible region
        chk("R5", "blank before start", int'(blank_o), 1);
        chk("R1", "hsync after reset", int'(hsync_o), 0);

        // master run with vsync_i held high (R6: must be ignored)
        @(negedge clk) sync_set = 1'b1;
        origin_now();
        chk("R6", "vsync_oe", int'(vsync_oe), 1);
        @(negedge clk);
        sync_set = 1'b0; disp_start = 1'b1; vsync_i = 1'b1;
        for (int i = 0; i < NV; i++) begin
            go_to(int'(TBL[i].k));
            if (i == 0) begin
                @(negedge clk) disp_start = 1'b0;
            end
            chk("R1", "hsync", int'(hsync_o), int'(TBL[i].hs));
            chk("R2", "vsync", int'(vsync_o), int'(TBL[i].vs));
            chk("R3_R4_R6", "blank", int'(blank_o), int'(TBL[i].bl));
            chk("R8", "refresh_valid", int'(refresh_valid), int'(TBL[i].hs));
            chk("R8", "draw_hold", int'(draw_hold), int'(TBL[i].hs));
            chk("R9", "refresh_addr", int'(refresh_addr), exp_ref);
        end
        @(negedge clk) vsync_i = 1'b0;

        // R5: both strobes together, sync-set wins
        @(negedge clk) begin sync_set = 1'b1; disp_start = 1'b1; end
        origin_now();
        chk("R5", "blank after joint strobes", int'(blank_o), 1);
        @(negedge clk) begin sync_set = 1'b0; disp_start = 1'b0; end
        go_to(3);
        chk("R5", "blank stays until start", int'(blank_o), 1);
        @(negedge clk) disp_start = 1'b1;
        go_to(4);
        chk("R5", "blank released by start", int'(blank_o), 0);
        @(negedge clk) disp_start = 1'b0;

        // R9: refresh frozen while dram mode is off
        @(negedge clk) begin a0 = refresh_addr; dram_mode = 1'b0; sync_set = 1'b1; end
        origin_now();
        @(negedge clk) sync_set = 1'b0;
        go_to(9);
        chk("R1", "hsync in sync phase", int'(hsync_o), 1);
        chk("R8", "refresh_valid dram off", int'(refresh_valid), 0);
        chk("R8", "draw_hold dram off", int'(draw_hold), 0);
        go_to(22);
        chk("R9", "addr frozen dram off", int'(refresh_addr), int'(a0));
        @(negedge clk) begin dram_mode = 1'b1; disp_start = 1'b1; end
        @(negedge clk) disp_start = 1'b0;

        // slave mode
        @(negedge clk) master_mode = 1'b0;
        #1;
        chk("R7", "vsync_oe slave", int'(vsync_oe), 0);
        @(negedge clk) vsync_i = 1'b1;
        origin_now();
        go_to(2);
        chk("R7", "hsync near origin", int'(hsync_o), 0);
        chk("R7", "blank near origin", int'(blank_o), 0);
        vsync_i = 1'b1;
        go_to(4);
        vsync_i = 1'b0;
        go_to(8);
        chk("R7", "hsync start after edge restart", int'(hsync_o), 1);
        go_to(11);
        chk("R7", "hsync end after edge restart", int'(hsync_o), 0);
        go_to(65);
        chk("R7", "internal vsync in slave", int'(vsync_o), 1);
        chk("R9", "refresh_addr slave", int'(refresh_addr), exp_ref);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule